// File: doc/BRIEF.md
# Width-Converting DMA Byte FIFO with Lane Parity

This block is a 16-byte buffer that sits between a 16-bit DMA data port and an 8-bit peripheral byte port. It moves command, data, status and message bytes in either direction. On the DMA side it takes or gives 16-bit words, each with one parity bit per byte lane. On the byte side it takes or gives a single byte with its parity bit. A direction input picks which side fills the buffer and which side empties it.

The buffer raises a burst DMA request once eight byte slots are free (DMA filling) or once eight bytes are held (DMA emptying). Parity on the DMA port can be ignored, generated and checked, or carried through untouched. After an aborted transfer, a drain input stops all writes and lets either port read out the remaining bytes. A lone last byte leaves on the low DMA lane with the high lane flagged invalid. A synchronous flush empties the buffer in one cycle.

Top module: `dma_width_fifo`

## Requirements
- R1: While `rst` is high, on every clock edge `byte_count` becomes 0, `fifo_empty` 1, `fifo_full` 0, `dma_req` 0 and `par_err` 0.
- R2: With `dir`=1 (DMA fills, byte port empties), an accepted DMA word is stored as two bytes. Bits 7:0 are read first on `pb_rdata`, then bits 15:8, and words keep their arrival order.
- R3: With `dir`=0 (byte port fills, DMA empties), the DMA port reads out two stored bytes as one word. The older byte is on bits 7:0 and the newer on bits 15:8, and `dma_rhi_valid` is 1.
- R4: `byte_count` (registered, 0..16) is the number of stored bytes, with `fifo_full` at 16 and `fifo_empty` at 0. A DMA word write is taken only when `dir`=1, `drain`=0 and at least two slots are free (`dma_wr_room`). A byte write is taken only when `dir`=0, `drain`=0 and the buffer is not full. Reads of an empty buffer are ignored. A refused access leaves the contents unchanged.
- R5: `dma_req` is registered and follows the level after the same edge. With `drain`=0 it is 1 when `dir`=1 and 16-`byte_count` >= 8, or when `dir`=0 and `byte_count` >= 8. With `drain`=1 it is 1 whenever bytes remain.
- R6: `par_mode`=2'b01 (generate/check) uses odd parity per byte (bit = XNOR of the byte's bits). An accepted DMA write whose `dma_wpar[i]` differs for any lane sets `par_err` at the next edge. The flag then stays 1 until an `err_clr` cycle with no new error; a new error wins over the clear.
- R7: `par_mode`=2'b10 (pass-through) stores the incoming parity bit with each byte (`dma_wpar[0]`/`dma_wpar[1]` for the low/high lane, `pb_wpar` for the byte port). It presents that bit unchanged with the byte on the other port, and `par_err` is never set.
- R8: In `par_mode` 2'b00 (off), 2'b01 and 2'b11, the incoming parity on both ports is ignored for storage. Every byte leaves with its odd parity bit generated.
- R9: While `drain`=1, all writes are refused. The DMA port may read when two or more bytes remain, and also when exactly one remains: then that byte is on bits 7:0, bits 15:8 and `dma_rpar[1]` are 0 and `dma_rhi_valid` is 0. The byte port may read in either direction. A DMA read in the same cycle takes priority over a byte read.
- R10: A cycle with `flush`=1 empties the buffer. `byte_count` is 0 and `fifo_empty` is 1 after that edge, whatever else is requested.
- R11: Either port may stall for any number of cycles, and any mix of accepted reads and writes delivers every byte once, in order, with its parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the buffer at this edge |
| dir | input | 1 | 1: DMA writes, byte port reads; 0: the reverse |
| drain | input | 1 | Residue readout: block writes, open both read sides |
| par_mode | input | 2 | 00 off, 01 generate/check, 10 pass-through, 11 as off |
| err_clr | input | 1 | Clear the sticky parity error |
| dma_wr | input | 1 | DMA word write request |
| dma_wdata | input | 16 | DMA write word, low byte first |
| dma_wpar | input | 2 | DMA write parity, one bit per lane |
| dma_wr_room | output | 1 | A DMA word write would be accepted now |
| dma_rd | input | 1 | DMA word read request |
| dma_rdata | output | 16 | DMA read word (head bytes) |
| dma_rpar | output | 2 | DMA read parity, one bit per lane |
| dma_rhi_valid | output | 1 | High lane of dma_rdata holds a byte |
| dma_rd_avail | output | 1 | A DMA read would be accepted now |
| pb_wr | input | 1 | Byte write request |
| pb_wdata | input | 8 | Byte write data |
| pb_wpar | input | 1 | Byte write parity |
| pb_rd | input | 1 | Byte read request |
| pb_rdata | output | 8 | Head byte |
| pb_rpar | output | 1 | Head byte parity |
| dma_req | output | 1 | Burst DMA request |
| byte_count | output | 5 | Stored byte count |
| fifo_full | output | 1 | 16 bytes stored |
| fifo_empty | output | 1 | No bytes stored |
| par_err | output | 1 | Sticky DMA parity error |

## Verification
The bound checker watches the level invariants on every cycle. It checks that the count never passes 16, that full and empty agree with the count and never coincide, and that full always withholds DMA write room. It also checks that the count moves by at most two bytes per edge, that flush empties, that drain never lets the count grow, that the parity flag holds until cleared, and that an invalid high lane reads as zero. Byte order across the width change, the parity bit carried or generated for each byte, the request thresholds at seven and eight and the lone-byte exit during drain depend on data history. Only the bench's reference queue can show those, through directed fills to full and empty and long random runs with stalls on both ports.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

  typedef enum logic [1:0] {
    PAR_OFF   = 2'b00,
    PAR_CHECK = 2'b01,
    PAR_PASS  = 2'b10,
    PAR_RSVD  = 2'b11
  } par_mode_e;

  // One stored slot: the byte plus the parity bit that travels with it.
  typedef struct packed {
    logic       par;
    logic [7:0] data;
  } entry_t;

  // Odd parity: the bit that makes the total count of ones odd.
  function automatic logic odd_par(input logic [7:0] d);
    return ~^d;
  endfunction

endpackage

// File: rtl/dwf_lane_pack.sv
// Splits an inbound DMA word into byte slots (lane 0 = bits 7:0 first)
// and flags lanes whose incoming parity disagrees with odd parity.
module dwf_lane_pack
  import dwf_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES*8-1:0]    word,
  input  logic [LANES-1:0]      par_in,
  input  logic                  pass_mode,
  output entry_t [LANES-1:0]    lanes,
  output logic [LANES-1:0]      lane_bad
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] byte_i;
    logic       gen_par;
    assign byte_i        = word[i*8 +: 8];
    assign gen_par       = odd_par(byte_i);
    assign lanes[i].data = byte_i;
    assign lanes[i].par  = pass_mode ? par_in[i] : gen_par;
    assign lane_bad[i]   = par_in[i] != gen_par;
  end

endmodule

// File: rtl/dwf_lane_unpack.sv
// Builds the outbound DMA word from the head slots. Lanes beyond the
// stored level read as zero with zero parity and are marked invalid.
module dwf_lane_unpack
  import dwf_pkg::*;
#(
  parameter int LANES = 2,
  parameter int CW    = 5
) (
  input  entry_t [LANES-1:0]    head,
  input  logic [CW-1:0]         level,
  input  logic                  pass_mode,
  output logic [LANES*8-1:0]    word,
  output logic [LANES-1:0]      par_out,
  output logic [LANES-1:0]      lane_valid
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_valid[i]   = level > CW'(i);
    assign word[i*8 +: 8]  = lane_valid[i] ? head[i].data : 8'h00;
    assign par_out[i]      = !lane_valid[i] ? 1'b0 :
                             pass_mode ? head[i].par : odd_par(head[i].data);
  end

endmodule

// File: rtl/dwf_store.sv
// Circular slot array. Up to LANES slots written and up to LANES
// slots retired per cycle; the LANES oldest slots are always visible.
module dwf_store
  import dwf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [LW-1:0]       push_n,
  input  entry_t [LANES-1:0]  push_data,
  input  logic [LW-1:0]       pop_n,
  output entry_t [LANES-1:0]  head
);

  entry_t         mem [DEPTH];
  logic [PW-1:0]  wr_ptr;
  logic [PW-1:0]  rd_ptr;

  // Storage has no reset so it maps onto distributed memory.
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(push_n)) begin
        mem[wr_ptr + PW'(i)] <= push_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(push_n);
      rd_ptr <= rd_ptr + PW'(pop_n);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_head
    assign head[i] = mem[rd_ptr + PW'(i)];
  end

endmodule

// File: rtl/dwf_ctrl.sv
// Level counter with registered full/empty and burst request.
module dwf_ctrl #(
  parameter int DEPTH = 16,
  parameter int THR   = 8,
  parameter int LANES = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(LANES + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic           dir,
  input  logic           drain,
  input  logic [LW-1:0]  push_n,
  input  logic [LW-1:0]  pop_n,
  output logic [CW-1:0]  count_q,
  output logic           full_q,
  output logic           empty_q,
  output logic           req_q
);

  logic [CW-1:0] count_next;
  logic [CW-1:0] free_next;
  logic          req_next;

  always_comb begin
    if (flush) count_next = '0;
    else       count_next = count_q + CW'(push_n) - CW'(pop_n);
    free_next = CW'(DEPTH) - count_next;
    if (drain)    req_next = count_next != '0;
    else if (dir) req_next = free_next >= CW'(THR);
    else          req_next = count_next >= CW'(THR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      count_q <= count_next;
      full_q  <= count_next == CW'(DEPTH);
      empty_q <= count_next == '0;
      req_q   <= req_next;
    end
  end

endmodule

// File: rtl/dma_width_fifo.sv
// 16-bit DMA word port <-> 8-bit byte port buffer with lane parity.
// DEPTH must be a power of two.
module dma_width_fifo
  import dwf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int THR   = 8,
  parameter int LANES = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(LANES + 1),
  localparam int DW   = LANES * 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic           dir,
  input  logic           drain,
  input  logic [1:0]     par_mode,
  input  logic           err_clr,
  input  logic           dma_wr,
  input  logic [DW-1:0]  dma_wdata,
  input  logic [LANES-1:0] dma_wpar,
  output logic           dma_wr_room,
  input  logic           dma_rd,
  output logic [DW-1:0]  dma_rdata,
  output logic [LANES-1:0] dma_rpar,
  output logic           dma_rhi_valid,
  output logic           dma_rd_avail,
  input  logic           pb_wr,
  input  logic [7:0]     pb_wdata,
  input  logic           pb_wpar,
  input  logic           pb_rd,
  output logic [7:0]     pb_rdata,
  output logic           pb_rpar,
  output logic           dma_req,
  output logic [CW-1:0]  byte_count,
  output logic           fifo_full,
  output logic           fifo_empty,
  output logic           par_err
);

  logic               pass_mode;
  logic               check_mode;
  logic               dma_wr_ok, dma_rd_ok, pb_wr_ok, pb_rd_ok;
  logic [LW-1:0]      push_n, pop_n;
  entry_t [LANES-1:0] in_lanes;
  entry_t [LANES-1:0] push_data;
  entry_t [LANES-1:0] head;
  logic [LANES-1:0]   lane_bad;
  logic [LANES-1:0]   lane_valid;
  logic               err_q;
  entry_t             pb_entry;

  assign pass_mode  = par_mode == PAR_PASS;
  assign check_mode = par_mode == PAR_CHECK;

  // ---- admission --------------------------------------------------
  assign dma_wr_room  = dir && !drain && (byte_count <= CW'(DEPTH - LANES));
  assign dma_rd_avail = (!dir || drain) &&
                        ((byte_count >= CW'(LANES)) || (drain && !fifo_empty));

  assign dma_wr_ok = !flush && dma_wr && dma_wr_room;
  assign dma_rd_ok = !flush && dma_rd && dma_rd_avail;
  assign pb_wr_ok  = !flush && pb_wr && !dir && !drain && !fifo_full;
  assign pb_rd_ok  = !flush && pb_rd && (dir || drain) && !fifo_empty && !dma_rd_ok;

  always_comb begin
    push_n = '0;
    if (dma_wr_ok)     push_n = LW'(LANES);
    else if (pb_wr_ok) push_n = LW'(1);

    pop_n = '0;
    if (dma_rd_ok)     pop_n = (byte_count >= CW'(LANES)) ? LW'(LANES) : LW'(byte_count);
    else if (pb_rd_ok) pop_n = LW'(1);
  end

  // ---- write path -------------------------------------------------
  dwf_lane_pack #(.LANES(LANES)) u_pack (
    .word      (dma_wdata),
    .par_in    (dma_wpar),
    .pass_mode (pass_mode),
    .lanes     (in_lanes),
    .lane_bad  (lane_bad)
  );

  assign pb_entry.data = pb_wdata;
  assign pb_entry.par  = pass_mode ? pb_wpar : odd_par(pb_wdata);

  always_comb begin
    push_data = in_lanes;
    if (!dma_wr_ok) push_data[0] = pb_entry;
  end

  dwf_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push_n    (push_n),
    .push_data (push_data),
    .pop_n     (pop_n),
    .head      (head)
  );

  dwf_ctrl #(.DEPTH(DEPTH), .THR(THR), .LANES(LANES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .dir     (dir),
    .drain   (drain),
    .push_n  (push_n),
    .pop_n   (pop_n),
    .count_q (byte_count),
    .full_q  (fifo_full),
    .empty_q (fifo_empty),
    .req_q   (dma_req)
  );

  // ---- read path --------------------------------------------------
  dwf_lane_unpack #(.LANES(LANES), .CW(CW)) u_unpack (
    .head       (head),
    .level      (byte_count),
    .pass_mode  (pass_mode),
    .word       (dma_rdata),
    .par_out    (dma_rpar),
    .lane_valid (lane_valid)
  );

  assign dma_rhi_valid = lane_valid[LANES-1];
  assign pb_rdata      = dma_rdata[7:0];
  assign pb_rpar       = dma_rpar[0];

  // ---- sticky parity error ---------------------------------------
  always_ff @(posedge clk) begin
    if (rst)                                 err_q <= 1'b0;
    else if (dma_wr_ok && check_mode && |lane_bad) err_q <= 1'b1;
    else if (err_clr)                        err_q <= 1'b0;
  end

  assign par_err = err_q;

endmodule

// File: rtl/dwf_checker.sv
module dwf_checker #(
  parameter int DEPTH = 16,
  parameter int LANES = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               drain,
  input logic               err_clr,
  input logic               par_err,
  input logic [CW-1:0]      byte_count,
  input logic               fifo_full,
  input logic               fifo_empty,
  input logic               dma_wr_room,
  input logic               dma_rhi_valid,
  input logic [LANES*8-1:0] dma_rdata
);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(byte_count) <= DEPTH);

  // R4
  full_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  // R4
  empty_level_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_empty == (byte_count == '0));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !dma_wr_room);

  // R4
  step_chk: assert property (@(posedge clk) disable iff (rst)
    !flush |=> int'(byte_count) <= int'($past(byte_count)) + LANES);

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fifo_empty && byte_count == '0));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err && !err_clr) |=> par_err);

  // R9
  drain_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (drain && !flush) |=> int'(byte_count) <= int'($past(byte_count)));

  // R9
  hi_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_rhi_valid |-> dma_rdata[LANES*8-1:8] == '0);

endmodule

bind dma_width_fifo dwf_checker #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .flush         (flush),
  .drain         (drain),
  .err_clr       (err_clr),
  .par_err       (par_err),
  .byte_count    (byte_count),
  .fifo_full     (fifo_full),
  .fifo_empty    (fifo_empty),
  .dma_wr_room   (dma_wr_room),
  .dma_rhi_valid (dma_rhi_valid),
  .dma_rdata     (dma_rdata)
);

// File: tb/dma_width_fifo_tb.sv
module dma_width_fifo_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0, dir = 1'b0, drain = 1'b0, err_clr = 1'b0;
  logic [1:0]  par_mode = 2'b00;
  logic        dma_wr = 1'b0, dma_rd = 1'b0, pb_wr = 1'b0, pb_rd = 1'b0;
  logic [15:0] dma_wdata = '0;
  logic [1:0]  dma_wpar = '0;
  logic [7:0]  pb_wdata = '0;
  logic        pb_wpar = 1'b0;
  logic        dma_wr_room, dma_rhi_valid, dma_rd_avail, pb_rpar;
  logic [15:0] dma_rdata;
  logic [1:0]  dma_rpar;
  logic [7:0]  pb_rdata;
  logic        dma_req, fifo_full, fifo_empty, par_err;
  logic [4:0]  byte_count;

  always #10 clk = ~clk;

  dma_width_fifo u_dut (
    .clk(clk), .rst(rst), .flush(flush), .dir(dir), .drain(drain),
    .par_mode(par_mode), .err_clr(err_clr),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_wpar(dma_wpar), .dma_wr_room(dma_wr_room),
    .dma_rd(dma_rd), .dma_rdata(dma_rdata), .dma_rpar(dma_rpar),
    .dma_rhi_valid(dma_rhi_valid), .dma_rd_avail(dma_rd_avail),
    .pb_wr(pb_wr), .pb_wdata(pb_wdata), .pb_wpar(pb_wpar),
    .pb_rd(pb_rd), .pb_rdata(pb_rdata), .pb_rpar(pb_rpar),
    .dma_req(dma_req), .byte_count(byte_count), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .par_err(par_err)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [8:0] q[$];
  bit  m_err = 1'b0;

  function automatic logic oddp(input logic [7:0] d);
    return ~^d;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One clock: check read data before the edge, update the reference
  // queue at the edge, check registered status after it.
  task automatic step(input string dtag);
    int  cnt, npop;
    bit  wr_ok, rd_ok, pw_ok, pr_ok, bad;
    string stag;
    logic [8:0] e;
    #1;
    cnt   = q.size();
    wr_ok = !flush && dma_wr && dir && !drain && cnt <= 14;
    rd_ok = !flush && dma_rd && (!dir || drain) && (cnt >= 2 || (drain && cnt >= 1));
    pr_ok = !flush && pb_rd && (dir || drain) && cnt > 0 && !rd_ok;
    pw_ok = !flush && pb_wr && !dir && !drain && cnt < 16;
    bad   = (dma_wpar[0] != oddp(dma_wdata[7:0])) || (dma_wpar[1] != oddp(dma_wdata[15:8]));
    if (!rst && rd_ok) begin
      chk(dtag, "dma lo data", dma_rdata[7:0], q[0][7:0]);
      chk(dtag, "dma lo par", dma_rpar[0], q[0][8]);
      if (cnt >= 2) begin
        chk(dtag, "dma hi data", dma_rdata[15:8], q[1][7:0]);
        chk(dtag, "dma hi par", dma_rpar[1], q[1][8]);
        chk(dtag, "dma hi valid", dma_rhi_valid, 1);
      end else begin
        chk("R9", "lone byte hi lane", {dma_rhi_valid, dma_rpar[1], dma_rdata[15:8]}, 0);
      end
    end
    if (!rst && pr_ok) begin
      chk(dtag, "byte data", pb_rdata, q[0][7:0]);
      chk(dtag, "byte par", pb_rpar, q[0][8]);
    end
    stag = rst ? "R1" : flush ? "R10" : "R4";
    @(posedge clk);
    if (rst) m_err = 1'b0;
    else if (wr_ok && par_mode == 2'b01 && bad) m_err = 1'b1;
    else if (err_clr) m_err = 1'b0;
    if (rst || flush) q.delete();
    else begin
      npop = rd_ok ? ((cnt >= 2) ? 2 : 1) : (pr_ok ? 1 : 0);
      for (int k = 0; k < npop; k++) void'(q.pop_front());
      if (wr_ok) begin
        e = {(par_mode == 2'b10) ? dma_wpar[0] : oddp(dma_wdata[7:0]), dma_wdata[7:0]};
        q.push_back(e);
        e = {(par_mode == 2'b10) ? dma_wpar[1] : oddp(dma_wdata[15:8]), dma_wdata[15:8]};
        q.push_back(e);
      end
      if (pw_ok) q.push_back({(par_mode == 2'b10) ? pb_wpar : oddp(pb_wdata), pb_wdata});
    end
    @(negedge clk);
    cnt = q.size();
    chk(stag, "byte_count", byte_count, cnt);
    chk(stag, "fifo_full", fifo_full, cnt == 16);
    chk(stag, "fifo_empty", fifo_empty, cnt == 0);
    chk(rst ? "R1" : "R5", "dma_req", dma_req,
        rst ? 0 : drain ? (cnt != 0) : dir ? ((16 - cnt) >= 8) : (cnt >= 8));
    chk(rst ? "R1" : "R6", "par_err", par_err, m_err);
  endtask

  task automatic idle();
    dma_wr = 0; dma_rd = 0; pb_wr = 0; pb_rd = 0; flush = 0; err_clr = 0;
  endtask

  task automatic do_flush();
    idle(); flush = 1; step("R10"); flush = 0;
  endtask

  task automatic put_word(input logic [15:0] w, input bit good, input string t);
    idle(); dma_wr = 1; dma_wdata = w;
    dma_wpar = {oddp(w[15:8]), oddp(w[7:0])} ^ (good ? 2'b00 : 2'b01);
    step(t);
  endtask

  task automatic put_byte(input logic [7:0] b, input logic p, input string t);
    idle(); pb_wr = 1; pb_wdata = b; pb_wpar = p; step(t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd51966));
    @(negedge clk);
    // R1: reset state
    repeat (3) step("R1");
    rst = 0;
    step("R1");

    // R3 / R4: fill to full from the byte side, overflow refused, drain by words
    dir = 0; par_mode = 2'b00;
    for (int i = 0; i < 17; i++) put_byte(8'(8'h10 + i), 1'b0, "R3");
    idle(); dma_wr = 1; dma_wdata = 16'hdead; step("R4");
    idle(); dma_rd = 1;
    for (int i = 0; i < 9; i++) step("R3");

    // R2 / R5: DMA fills, request drops at 8 free, byte side empties
    idle(); dir = 1; step("R5");
    for (int i = 0; i < 9; i++) put_word(16'(16'ha100 + i * 16'h0203), 1'b1, "R2");
    idle(); pb_rd = 1;
    for (int i = 0; i < 17; i++) step("R2");

    // R6 / R8: bad parity sets flag, flag holds, clear releases it
    par_mode = 2'b01;
    put_word(16'h3c5a, 1'b1, "R8");
    put_word(16'h0f0f, 1'b0, "R6");
    idle(); step("R6"); step("R6");
    err_clr = 1; step("R6");
    idle(); pb_rd = 1;
    for (int i = 0; i < 4; i++) step("R8");

    // R7: pass-through keeps arbitrary parity bits in both directions
    par_mode = 2'b10;
    idle(); dma_wr = 1; dma_wdata = 16'h8001; dma_wpar = 2'b00; step("R7");
    dma_wdata = 16'h7e7e; dma_wpar = 2'b11; step("R7");
    idle(); pb_rd = 1;
    for (int i = 0; i < 4; i++) step("R7");
    idle(); dir = 0;
    put_byte(8'h01, 1'b0, "R7"); put_byte(8'hff, 1'b1, "R7"); put_byte(8'h55, 1'b1, "R7");
    idle(); dma_rd = 1; step("R7");

    // R9: drain with an odd residue, writes refused, lone byte on low lane
    par_mode = 2'b00;
    put_byte(8'h66, 1'b0, "R9"); put_byte(8'h77, 1'b0, "R9");
    idle(); drain = 1; step("R9");
    pb_wr = 1; pb_wdata = 8'hee; step("R9");
    idle(); dma_rd = 1; step("R9"); step("R9"); step("R9");
    drain = 0;

    // R10: flush from a partly filled state with a write pending
    dir = 1;
    put_word(16'h1234, 1'b1, "R10"); put_word(16'h5678, 1'b1, "R10");
    idle(); flush = 1; dma_wr = 1; step("R10");
    idle(); step("R10");

    // R11: random traffic with stalls on both ports
    for (int ph = 0; ph < 40; ph++) begin
      dir = 1'($urandom % 2);
      par_mode = 2'($urandom % 3);
      do_flush();
      for (int c = 0; c < 200; c++) begin
        dma_wr    = ($urandom % 3) == 0;
        dma_rd    = ($urandom % 3) == 0;
        pb_wr     = ($urandom % 2) == 0;
        pb_rd     = ($urandom % 2) == 0;
        dma_wdata = 16'($urandom);
        dma_wdata = dma_wdata;
        dma_wpar  = {oddp(dma_wdata[15:8]), oddp(dma_wdata[7:0])};
        if (par_mode != 2'b01 || ($urandom % 16) == 0) dma_wpar = 2'($urandom);
        pb_wdata  = 8'($urandom);
        pb_wpar   = 1'($urandom);
        err_clr   = ($urandom % 20) == 0;
        flush     = ($urandom % 150) == 0;
        step("R11");
      end
      idle(); drain = 1;
      for (int c = 0; c < 30; c++) begin
        dma_rd = 1'($urandom % 2);
        pb_rd  = 1'($urandom % 2);
        step("R11");
      end
      drain = 0;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule